// File: doc/BRIEF.md
# Tile Background Fetch Sequencer

This block runs the memory read schedule for a tile-based background layer and turns the fetched bytes into a 2-bit pixel index per dot. An external timing source supplies the dot counter (0 to 340) and the scanline number. For every 8-dot tile slot on a visible line, the block reads four bytes over a simple read port: a name byte, an attribute byte, and the low and high bitplane bytes of one pattern row. These are gathered into a staging register set. When the last byte arrives, the whole set is copied into the current-tile set that the pixel selector draws from.

The memory returns data one clock after the address is presented. Each read therefore takes an even phase (address out) and the following odd phase (data captured). A pattern-bank select input chooses which 4 KiB half of pattern space the bitplanes come from. The block also raises a strobe that holds the sprite-memory address register at zero during the sprite-loading part of visible and pre-render lines. Palette lookup, sprites and scrolling belong to neighbouring blocks.

Top module: `bg_fetch_seq`

## Requirements
- R1: Fetching and drawing happen only on dots 1 to 248 of lines below 240 while `bg_en` is 1. Dot 0 is idle, and with `bg_en` at 0 nothing is read and `pix_valid` stays 0.
- R2: The phase is (dot − 1) mod 8. Reads are issued with `mem_rd_en` high on phases 0 (name), 2 (attribute), 4 (low plane) and 6 (high plane). Data is taken from `mem_rdata` on the following odd phase. `mem_rd_en` is low on every other dot.
- R3: The name read address is 0x2000 + (line / 8) × 32 + tile, where tile = (dot − 1) / 8.
- R4: The attribute read address is 0x23C0 + (line / 32) × 8 + tile / 4.
- R5: The low-plane address is `pat_sel` × 0x1000 + name × 16 + (line mod 8), using the name byte fetched in the same slot. The high-plane address is that value plus 8.
- R6: At the end of phase 7 the staging set (name, attribute, low plane, and the high plane just arrived) is copied into the current set. The current set is unchanged on all other dots. As a result, a tile fetched in slot k is drawn in slot k+1, and `tile_attr` shows that tile's attribute byte.
- R7: For an active dot d, the outputs one clock later are `pix_valid` = 1 and `pix_idx` = {high bit, low bit}. The bit is taken at position 7 − ((d − 1) mod 8) of the current bitplanes, so the MSB comes first. On inactive dots, `pix_valid`, `pix_idx` and `tile_attr` are 0.
- R8: `spr_addr_clr` is high on dots 257 to 320 of lines below 240 and of line 261, whatever the value of `bg_en`. It is low otherwise.
- R9: Reset clears the staging and current sets and the pixel outputs. The first eight active dots after reset therefore draw index 0 with attribute 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dot | input | 9 | Dot counter within the line, 0 to 340 |
| line | input | 9 | Scanline number |
| bg_en | input | 1 | Background enable |
| pat_sel | input | 1 | Pattern bank select (0: 0x0000, 1: 0x1000) |
| mem_addr | output | 14 | Video memory read address |
| mem_rd_en | output | 1 | Read strobe for the current dot |
| mem_rdata | input | 8 | Read data, valid one clock after the address |
| pix_idx | output | 2 | Pixel index {high plane, low plane}, one clock after the dot |
| pix_valid | output | 1 | A pixel is drawn for the previous dot |
| tile_attr | output | 8 | Attribute byte of the tile being drawn |
| spr_addr_clr | output | 1 | Hold the sprite-memory address register at zero |

## Verification
The memory model fills every address with a hashed byte from a seeded value. A wrong row, column, bank or plane offset therefore reads a different byte and shows up in the pixel and attribute outputs, not only on the address bus. Directed lines cover:
- row 0 and pattern row 7, which tell the row term apart from the fine-row term;
- both pattern banks;
- the last visible line (239) and the first line past it (240);
- the pre-render line, which shows the sprite clear working without any fetches;
- a disabled line.

Randomly chosen lines, enables and banks follow. A line run directly after a reset separates a correctly cleared current set from stale tile data.

// File: rtl/bgf_pkg.sv
package bgf_pkg;

    localparam int DOT_W  = 9;
    localparam int LINE_W = 9;
    localparam int ADDR_W = 14;
    localparam int DATA_W = 8;
    localparam int PH_W   = 3;

    localparam logic [ADDR_W-1:0] NAME_BASE   = 14'h2000;
    localparam logic [ADDR_W-1:0] ATTR_BASE   = 14'h23C0;
    localparam logic [ADDR_W-1:0] BANK_STRIDE = 14'h1000;
    localparam logic [ADDR_W-1:0] PLANE_GAP   = 14'h0008;

    typedef enum logic [PH_W-1:0] {
        PH_NAME_A = 3'd0,
        PH_NAME_D = 3'd1,
        PH_ATTR_A = 3'd2,
        PH_ATTR_D = 3'd3,
        PH_LO_A   = 3'd4,
        PH_LO_D   = 3'd5,
        PH_HI_A   = 3'd6,
        PH_HI_D   = 3'd7
    } phase_e;

    typedef struct packed {
        logic [DATA_W-1:0] name;
        logic [DATA_W-1:0] attr;
        logic [DATA_W-1:0] lo;
        logic [DATA_W-1:0] hi;
    } tile_set_t;

    // tile column of a slot, taken at its first phase: dot / 8
    function automatic logic [ADDR_W-1:0] name_addr(input logic [LINE_W-1:0] ln,
                                                    input logic [DOT_W-1:0]  dt);
        logic [ADDR_W-1:0] row;
        logic [ADDR_W-1:0] col;
        row = ADDR_W'(ln >> 3);
        col = ADDR_W'(dt >> 3);
        return NAME_BASE + (row << 5) + col;
    endfunction

    function automatic logic [ADDR_W-1:0] attr_addr(input logic [LINE_W-1:0] ln,
                                                    input logic [DOT_W-1:0]  dt);
        logic [ADDR_W-1:0] row;
        logic [ADDR_W-1:0] col;
        row = ADDR_W'(ln >> 3);
        col = ADDR_W'(dt >> 3);
        return ATTR_BASE + ((row >> 2) << 3) + (col >> 2);
    endfunction

    function automatic logic [ADDR_W-1:0] pat_addr(input logic              bank,
                                                   input logic [DATA_W-1:0] name,
                                                   input logic [LINE_W-1:0] ln,
                                                   input logic              upper);
        logic [ADDR_W-1:0] a;
        a = ADDR_W'({name, 4'b0000}) + ADDR_W'(ln[2:0]);
        if (bank)  a = a + BANK_STRIDE;
        if (upper) a = a + PLANE_GAP;
        return a;
    endfunction

endpackage

// File: rtl/bgf_phase_dec.sv
module bgf_phase_dec
    import bgf_pkg::*;
#(
    parameter int LAST_DOT  = 248,
    parameter int VIS_LINES = 240,
    parameter int PRE_LINE  = 261,
    parameter int CLR_FIRST = 257,
    parameter int CLR_LAST  = 320
) (
    input  logic [DOT_W-1:0]  dot,
    input  logic [LINE_W-1:0] line,
    input  logic              bg_en,
    output phase_e            phase,
    output logic              active,
    output logic              spr_clr
);
    logic [DOT_W-1:0] dot_m1;
    logic             visible;
    logic             in_fetch;
    logic             in_clr;

    assign dot_m1   = dot - DOT_W'(1);
    assign phase    = phase_e'(dot_m1[PH_W-1:0]);
    assign visible  = line < LINE_W'(VIS_LINES);
    assign in_fetch = (dot != '0) && (dot <= DOT_W'(LAST_DOT));
    assign in_clr   = (dot >= DOT_W'(CLR_FIRST)) && (dot <= DOT_W'(CLR_LAST));
    assign active   = bg_en && visible && in_fetch;
    assign spr_clr  = in_clr && (visible || (line == LINE_W'(PRE_LINE)));

endmodule

// File: rtl/bgf_addr_gen.sv
module bgf_addr_gen
    import bgf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase,
    input  logic              active,
    input  logic [DOT_W-1:0]  dot,
    input  logic [LINE_W-1:0] line,
    input  logic              pat_sel,
    input  logic [DATA_W-1:0] name_byte,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_en
);
    always_comb begin
        mem_addr  = '0;
        mem_rd_en = 1'b0;
        if (active) begin
            unique case (phase)
                PH_NAME_A: begin mem_addr = name_addr(line, dot);                    mem_rd_en = 1'b1; end
                PH_ATTR_A: begin mem_addr = attr_addr(line, dot);                    mem_rd_en = 1'b1; end
                PH_LO_A:   begin mem_addr = pat_addr(pat_sel, name_byte, line, 1'b0); mem_rd_en = 1'b1; end
                PH_HI_A:   begin mem_addr = pat_addr(pat_sel, name_byte, line, 1'b1); mem_rd_en = 1'b1; end
                default:   ;
            endcase
        end
    end

    // R2: a read is always followed by a data cycle
    p_rd_spaced_r2: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> !mem_rd_en);

    // R3: name reads fall in the name table region
    p_name_region_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_en && phase == PH_NAME_A) |-> (mem_addr[13:10] == 4'b1000));

    // R4: attribute reads fall in the attribute block
    p_attr_region_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_en && phase == PH_ATTR_A) |-> (mem_addr[13:6] == 8'h8F));

    // R5: high plane sits a fixed gap above the low plane of the same slot
    p_plane_gap_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_en && phase == PH_HI_A && $past(mem_rd_en, 2))
            |-> (mem_addr == $past(mem_addr, 2) + PLANE_GAP));

endmodule

// File: rtl/bgf_tile_regs.sv
module bgf_tile_regs
    import bgf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  phase_e            phase,
    input  logic [DATA_W-1:0] mem_rdata,
    output tile_set_t         nxt,
    output tile_set_t         cur
);
    always_ff @(posedge clk) begin
        if (rst) begin
            nxt <= '0;
            cur <= '0;
        end else if (active) begin
            unique case (phase)
                PH_NAME_D: nxt.name <= mem_rdata;
                PH_ATTR_D: nxt.attr <= mem_rdata;
                PH_LO_D:   nxt.lo   <= mem_rdata;
                PH_HI_D: begin
                    nxt.hi <= mem_rdata;
                    cur    <= '{name: nxt.name, attr: nxt.attr, lo: nxt.lo, hi: mem_rdata};
                end
                default: ;
            endcase
        end
    end

    // R6: the drawing set only moves at the end of a slot
    p_cur_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !(active && phase == PH_HI_D) |=> $stable(cur));

    // R6: the name used for plane reads stays put after its capture
    p_name_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !(active && phase == PH_NAME_D) |=> $stable(nxt.name));

endmodule

// File: rtl/bgf_pix_sel.sv
module bgf_pix_sel
    import bgf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic [DOT_W-1:0]  dot,
    input  tile_set_t         cur,
    output logic [1:0]        pix_idx,
    output logic              pix_valid,
    output logic [DATA_W-1:0] tile_attr
);
    logic [DOT_W-1:0] dot_m1;
    logic [PH_W-1:0]  bit_pos;
    logic [1:0]       idx_d;

    assign dot_m1  = dot - DOT_W'(1);
    assign bit_pos = PH_W'(7) - dot_m1[PH_W-1:0];

    // one 2-bit slice per column, selected MSB first
    logic [1:0] col_px [8];
    for (genvar g = 0; g < 8; g++) begin : g_col
        assign col_px[g] = {cur.hi[g], cur.lo[g]};
    end
    assign idx_d = col_px[bit_pos];

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_idx   <= '0;
            pix_valid <= 1'b0;
            tile_attr <= '0;
        end else begin
            pix_valid <= active;
            pix_idx   <= active ? idx_d : 2'b00;
            tile_attr <= active ? cur.attr : '0;
        end
    end

    // R7: quiet outputs when no pixel is drawn
    p_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !pix_valid |-> (pix_idx == 2'b00 && tile_attr == '0));

endmodule

// File: rtl/bg_fetch_seq.sv
module bg_fetch_seq
    import bgf_pkg::*;
#(
    parameter int LAST_DOT  = 248,
    parameter int VIS_LINES = 240,
    parameter int PRE_LINE  = 261,
    parameter int CLR_FIRST = 257,
    parameter int CLR_LAST  = 320
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [8:0]        dot,
    input  logic [8:0]        line,
    input  logic              bg_en,
    input  logic              pat_sel,
    output logic [13:0]       mem_addr,
    output logic              mem_rd_en,
    input  logic [7:0]        mem_rdata,
    output logic [1:0]        pix_idx,
    output logic              pix_valid,
    output logic [7:0]        tile_attr,
    output logic              spr_addr_clr
);
    phase_e    phase;
    logic      active;
    tile_set_t nxt;
    tile_set_t cur;

    bgf_phase_dec #(
        .LAST_DOT (LAST_DOT),
        .VIS_LINES(VIS_LINES),
        .PRE_LINE (PRE_LINE),
        .CLR_FIRST(CLR_FIRST),
        .CLR_LAST (CLR_LAST)
    ) u_dec (
        .dot    (dot),
        .line   (line),
        .bg_en  (bg_en),
        .phase  (phase),
        .active (active),
        .spr_clr(spr_addr_clr)
    );

    bgf_addr_gen u_addr (
        .clk      (clk),
        .rst      (rst),
        .phase    (phase),
        .active   (active),
        .dot      (dot),
        .line     (line),
        .pat_sel  (pat_sel),
        .name_byte(nxt.name),
        .mem_addr (mem_addr),
        .mem_rd_en(mem_rd_en)
    );

    bgf_tile_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .active   (active),
        .phase    (phase),
        .mem_rdata(mem_rdata),
        .nxt      (nxt),
        .cur      (cur)
    );

    bgf_pix_sel u_pix (
        .clk      (clk),
        .rst      (rst),
        .active   (active),
        .dot      (dot),
        .cur      (cur),
        .pix_idx  (pix_idx),
        .pix_valid(pix_valid),
        .tile_attr(tile_attr)
    );

    // R1: dot 0 never produces a pixel
    p_idle_dot0_r1: assert property (@(posedge clk) disable iff (rst)
        (dot == 9'd0) |=> !pix_valid);

    // R1: a disabled background draws nothing and reads nothing
    p_bg_off_r1: assert property (@(posedge clk) disable iff (rst)
        !bg_en |-> (!mem_rd_en ##1 !pix_valid));

    // R8: the sprite address clear window opens on its first dot
    p_clr_start_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(spr_addr_clr) |-> (dot == 9'(CLR_FIRST)));

    // R9: reset leaves the pixel outputs quiet
    p_reset_quiet_r9: assert property (@(posedge clk)
        rst |=> (!pix_valid && pix_idx == 2'b00 && tile_attr == 8'h00));

endmodule

// File: tb/bg_fetch_seq_bench.sv
module bg_fetch_seq_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [8:0] dot = '0;
    logic [8:0] line = '0;
    logic       bg_en = 1'b0;
    logic       pat_sel = 1'b0;
    logic [13:0] mem_addr;
    logic        mem_rd_en;
    logic [7:0]  mem_rdata = '0;
    logic [1:0]  pix_idx;
    logic        pix_valid;
    logic [7:0]  tile_attr;
    logic        spr_addr_clr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [31:0] mem_seed;

    int  p_dot = 0, p_line = 0;
    bit  p_en = 0, p_sel = 0, p_fresh = 0, fresh = 0;

    always #4 clk = ~clk;

    bg_fetch_seq u_bg_fetch_seq (
        .clk(clk), .rst(rst), .dot(dot), .line(line), .bg_en(bg_en),
        .pat_sel(pat_sel), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
        .mem_rdata(mem_rdata), .pix_idx(pix_idx), .pix_valid(pix_valid),
        .tile_attr(tile_attr), .spr_addr_clr(spr_addr_clr)
    );

    function automatic logic [7:0] memf(int a);
        logic [31:0] x;
        x = (a * 32'h9E3779B1) ^ mem_seed;
        x = x ^ (x >> 13);
        return x[7:0];
    endfunction

    // one-clock read latency memory model
    always @(posedge clk) mem_rdata <= memf(int'(mem_addr));

    function automatic bit e_active(int d, int l, bit en);
        return en && d >= 1 && d <= 248 && l < 240;
    endfunction
    function automatic int e_name(int l, int k);  return 'h2000 + (l / 8) * 32 + k; endfunction
    function automatic int e_attr(int l, int k);  return 'h23C0 + (l / 32) * 8 + k / 4; endfunction
    function automatic int e_pat(bit s, int nm, int l, bit up);
        return s * 'h1000 + nm * 16 + l % 8 + (up ? 8 : 0);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_comb(int d, int l, bit en, bit s);
        int  ph, k, nm, ea;
        bit  rd, clr;
        ph = (d + 7) % 8;
        k  = (d - 1) / 8;
        rd = e_active(d, l, en) && (ph % 2 == 0);
        chk(mem_rd_en == rd, (en && l < 240 && d >= 1 && d <= 248) ? "R2" : "R1",
            "mem_rd_en", int'(mem_rd_en), int'(rd));
        if (rd) begin
            nm = int'(memf(e_name(l, k)));
            case (ph)
                0: ea = e_name(l, k);
                2: ea = e_attr(l, k);
                4: ea = e_pat(s, nm, l, 1'b0);
                default: ea = e_pat(s, nm, l, 1'b1);
            endcase
            chk(int'(mem_addr) == ea, ph == 0 ? "R3" : (ph == 2 ? "R4" : "R5"),
                "mem_addr", int'(mem_addr), ea);
        end
        clr = (l < 240 || l == 261) && d >= 257 && d <= 320;
        chk(spr_addr_clr == clr, "R8", "spr_addr_clr", int'(spr_addr_clr), int'(clr));
    endtask

    task automatic check_pix(int d, int l, bit en, bit s, bit fr);
        bit act;
        int k, nm, lo, hi, b, ei, eat;
        act = e_active(d, l, en);
        chk(pix_valid == act, "R1", "pix_valid", int'(pix_valid), int'(act));
        if (!act) begin
            chk(pix_idx == 2'b00 && tile_attr == 8'h00, "R7", "idle pix/attr",
                int'({tile_attr, pix_idx}), 0);
        end else if (d >= 9) begin
            k   = (d - 1) / 8 - 1;
            nm  = int'(memf(e_name(l, k)));
            lo  = int'(memf(e_pat(s, nm, l, 1'b0)));
            hi  = int'(memf(e_pat(s, nm, l, 1'b1)));
            b   = 7 - ((d - 1) % 8);
            ei  = ((hi >> b) & 1) * 2 + ((lo >> b) & 1);
            eat = int'(memf(e_attr(l, k)));
            chk(int'(pix_idx) == ei, "R7", "pix_idx", int'(pix_idx), ei);
            chk(int'(tile_attr) == eat, "R6", "tile_attr", int'(tile_attr), eat);
        end else if (fr) begin
            chk(pix_idx == 2'b00 && tile_attr == 8'h00, "R9", "post-reset tile",
                int'({tile_attr, pix_idx}), 0);
        end
    endtask

    task automatic run_line(int l, bit en, bit s);
        for (int d = 0; d <= 340; d++) begin
            @(negedge clk);
            check_pix(p_dot, p_line, p_en, p_sel, p_fresh);
            dot = 9'(d); line = 9'(l); bg_en = en; pat_sel = s;
            #1;
            check_comb(d, l, en, s);
            p_dot = d; p_line = l; p_en = en; p_sel = s; p_fresh = fresh;
        end
        fresh = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; dot = '0; line = '0; bg_en = 1'b1; pat_sel = 1'b0;
        repeat (3) @(negedge clk);
        chk(!pix_valid && pix_idx == 2'b00 && tile_attr == 8'h00, "R9", "reset outputs",
            int'({tile_attr, pix_idx, pix_valid}), 0);
        chk(!mem_rd_en, "R9", "reset read strobe", int'(mem_rd_en), 0);
        rst = 1'b0;
        p_dot = 0; p_line = 0; p_en = 0; p_sel = 0; p_fresh = 0;
        fresh = 1'b1;
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        mem_seed = $urandom;
        do_reset();
        run_line(0, 1, 0);     // R9 fresh current set, then R3/R5 row 0
        run_line(7, 1, 1);     // R5 fine row 7, upper bank
        run_line(239, 1, 0);   // R1 last visible line
        run_line(240, 1, 1);   // R1 first line past visible, R8 no clear
        run_line(261, 1, 0);   // R8 pre-render clear, no fetch
        run_line(100, 0, 1);   // R1 disabled, R8 clear still present
        for (int i = 0; i < 8; i++) begin
            run_line(int'($urandom % 262), ($urandom % 4) != 0, 1'($urandom));
        end
        do_reset();
        run_line(int'($urandom % 240), 1, 1);
        @(negedge clk);
        check_pix(p_dot, p_line, p_en, p_sel, p_fresh);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL all watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule